// File: doc/BRIEF.md
# Peripheral Bus Window Timing Sequencer

This block owns the single 32-bit setup word of one external peripheral memory window and runs the timing of every internal request aimed at it. A request carries an address, a read/write flag, a 16-bit or 8-bit item size, a burst length for reads, and write data. The block compares the upper address bits with the programmed window base. On a hit it drives an external 8- or 16-bit bus, sequencing the offset address, chip-select, a read or write strobe and the data lanes. The wait time between phases is taken from coarse encoded fields in the setup word.

An access starts with one address cycle. The first strobe then waits out the address-to-data count. Later read beats are spaced by the data-to-data count, which can fall back to the address-to-data count. After the last beat a recovery period holds the block busy with chip-select released. On an 8-bit bus a 16-bit item is split into two byte beats. Read items come back on a response pulse, and every request ends with a done pulse. A miss or a reserved bus width ends the request with an error and leaves the external bus untouched.

Top module: `pbw_seq`

## Requirements
- R1: Reset loads the setup word with base bits 31:12 zero, data-to-data code (bits 11:9) 001, recovery code (bits 8:6) 111, bit 5 zero and address-to-data code (bits 4:2) 111. Width bits 1:0 load 00 (8-bit) when `boot_narrow_n` is low and 01 (16-bit) when it is high, giving 0x3DC or 0x3DD.
- R2: A setup write stores every bit except bit 5, which always reads back zero.
- R3: A request hits only when `req_addr[31:WIN_BITS]` equals setup bits 31:WIN_BITS. A miss never lowers chip-select, and it raises `done` and `err` together one cycle after acceptance.
- R4: When setup bits 1:0 are 10 or 11, a request behaves as in R3 (error, no bus activity).
- R5: Chip-select falls in a one-cycle address phase. The first strobe comes after exactly A idle cycles, where address-to-data code 000/001/010/011 gives A = 4/8/12/16 and any other code gives 20.
- R6: Between consecutive read strobes there are exactly D cycles. Data-to-data code 000 or 001 gives D = A, codes 010/011/100/101 give 4/8/12/16, and other codes give 20.
- R7: After the last strobe, `busy` stays high with chip-select released for exactly R cycles. Recovery code 000/001/010/011/100 gives R = 1/4/8/12/16, and other codes give 20. The block then returns to idle and accepts a new request.
- R8: A write carries a single item. Its strobe is the write strobe, and on an 8-bit bus its second byte beat is also preceded by A cycles.
- R9: On an 8-bit bus (width 00) a 16-bit item is two beats, low byte first on lanes 7:0. The read item is returned as {second byte, first byte}.
- R10: Beat k of an access drives `pb_addr` = request offset + k × step, with step 1 on an 8-bit bus and 2 on a 16-bit bus. An 8-bit item uses lanes 7:0 only, and upper read lanes are returned as zero.
- R11: Each read item gives one `rsp_valid` pulse in the cycle after its final strobe. `done` with `err` low pulses in the cycle after the last strobe.
- R12: Wait counts are captured when a request is accepted. A setup write during an access does not change that access's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_narrow_n | input | 1 | Active-low strap picking the reset bus width |
| cfg_we | input | 1 | Setup word write enable |
| cfg_wdata | input | 32 | Setup word write value |
| cfg_rdata | output | 32 | Current setup word |
| req_valid | input | 1 | Request present (taken when `busy` is low) |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit items, 0 = 8-bit items |
| req_len | input | LEN_W | Read burst item count minus one |
| req_wdata | input | 16 | Write item |
| busy | output | 1 | Access or recovery in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Qualifies `done` as an error |
| rsp_valid | output | 1 | Read item valid pulse |
| rsp_data | output | 16 | Read item |
| pb_addr | output | WIN_BITS | External offset address |
| pb_cs_n | output | 1 | External chip-select, active low |
| pb_rd_n | output | 1 | External read strobe, active low |
| pb_wr_n | output | 1 | External write strobe, active low |
| pb_wdata | output | 16 | External write lanes |
| pb_rdata | input | 16 | External read lanes |

## Verification
A wrong wait counter or a wrong code decode shifts a strobe by one or more cycles. The cycle-exact bench model then reports it on the first misplaced strobe, well before the access ends. A corrupted beat count or byte phase shows at once as a missing or extra strobe, a wrong `pb_addr`, or swapped bytes in `rsp_data` one cycle after the item's final strobe. A bad window compare or width check shows in the cycle right after acceptance, as chip-select falling where an error pulse is due, or the other way round.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

    localparam int CFG_W  = 32;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 5;

    localparam logic [CFG_W-1:0] CFG_WMASK = 32'hFFFF_FFDF;

    typedef struct packed {
        logic [19:0] base;
        logic [2:0]  dd_code;
        logic [2:0]  rec_code;
        logic        rsvd;
        logic [2:0]  ad_code;
        logic [1:0]  width;
    } win_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] a_wait;
        logic [CNT_W-1:0] d_wait;
        logic [CNT_W-1:0] r_wait;
    } timing_t;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_AWAIT, S_DATA, S_DWAIT, S_RECOV
    } seq_state_e;

    function automatic logic [CNT_W-1:0] ad_cycles(input logic [2:0] code);
        case (code)
            3'd0:    return CNT_W'(4);
            3'd1:    return CNT_W'(8);
            3'd2:    return CNT_W'(12);
            3'd3:    return CNT_W'(16);
            default: return CNT_W'(20);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] dd_cycles(input logic [2:0] code,
                                                   input logic [2:0] ad);
        case (code)
            3'd0, 3'd1: return ad_cycles(ad);
            3'd2:       return CNT_W'(4);
            3'd3:       return CNT_W'(8);
            3'd4:       return CNT_W'(12);
            3'd5:       return CNT_W'(16);
            default:    return CNT_W'(20);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] rec_cycles(input logic [2:0] code);
        case (code)
            3'd0:    return CNT_W'(1);
            3'd1:    return CNT_W'(4);
            3'd2:    return CNT_W'(8);
            3'd3:    return CNT_W'(12);
            3'd4:    return CNT_W'(16);
            default: return CNT_W'(20);
        endcase
    endfunction

endpackage

// File: rtl/pbw_cfg_reg.sv
module pbw_cfg_reg
    import pbw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output win_cfg_t         cfg
);

    win_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.base     <= '0;
            cfg_q.dd_code  <= 3'b001;
            cfg_q.rec_code <= 3'b111;
            cfg_q.rsvd     <= 1'b0;
            cfg_q.ad_code  <= 3'b111;
            cfg_q.width    <= strap_n ? 2'b01 : 2'b00;
        end else if (we) begin
            cfg_q <= win_cfg_t'(wdata & CFG_WMASK);
        end
    end

    assign cfg = cfg_q;

    // R2: a write lands in the next cycle with bit 5 cleared
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (cfg_q == win_cfg_t'($past(wdata) & CFG_WMASK)))
        else $error("R2 setup write not stored");

    // R1: width field follows the strap after reset
    a_r1_strap_width: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q.width == ($past(strap_n) ? 2'b01 : 2'b00)))
        else $error("R1 reset width wrong");

endmodule

// File: rtl/pbw_decode.sv
module pbw_decode
    import pbw_pkg::*;
#(
    parameter int WIN_BITS = 16
) (
    input  win_cfg_t              cfg,
    input  logic [31-WIN_BITS:0]  req_page,
    output logic                  hit,
    output logic                  width_ok,
    output logic                  bus8,
    output timing_t               timing
);

    logic [CFG_W-1:0] word;
    logic             unused_low;

    always_comb begin
        word          = cfg;
        hit           = (req_page == word[CFG_W-1:WIN_BITS]);
        width_ok      = (cfg.width[1] == 1'b0);
        bus8          = (cfg.width == 2'b00);
        timing.a_wait = ad_cycles(cfg.ad_code);
        timing.d_wait = dd_cycles(cfg.dd_code, cfg.ad_code);
        timing.r_wait = rec_cycles(cfg.rec_code);
    end

    assign unused_low = ^{word[WIN_BITS-1:0]};

endmodule

// File: rtl/pbw_fsm.sv
module pbw_fsm
    import pbw_pkg::*;
#(
    parameter int WIN_BITS = 16,
    parameter int LEN_W    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_wide,
    input  logic [LEN_W-1:0]    req_len,
    input  logic [WIN_BITS-1:0] req_off,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                hit,
    input  logic                width_ok,
    input  logic                bus8,
    input  timing_t             timing,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data,
    output logic [WIN_BITS-1:0] pb_addr,
    output logic                pb_cs_n,
    output logic                pb_rd_n,
    output logic                pb_wr_n,
    output logic [DATA_W-1:0]   pb_wdata,
    input  logic [DATA_W-1:0]   pb_rdata
);

    localparam int BEAT_W = LEN_W + 2;

    seq_state_e          state_q;
    logic [CNT_W-1:0]    cnt_q;
    timing_t             tim_q;
    logic                wr_q, split_q, narrow_q, b8_q, phase_q;
    logic [BEAT_W-1:0]   left_q;
    logic [WIN_BITS-1:0] addr_q;
    logic [DATA_W-1:0]   wdata_q, rdata_q;
    logic [7:0]          lo_q;
    logic                done_q, err_q, rv_q;

    logic [BEAT_W-1:0]   items, nbeats;
    logic                split_now, last_beat;

    always_comb begin
        split_now = bus8 && req_wide;
        items     = req_write ? BEAT_W'(1) : (BEAT_W'(req_len) + BEAT_W'(1));
        nbeats    = split_now ? (items << 1) : items;
        last_beat = (left_q == BEAT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            cnt_q    <= '0;
            tim_q    <= '0;
            wr_q     <= 1'b0;
            split_q  <= 1'b0;
            narrow_q <= 1'b0;
            b8_q     <= 1'b0;
            phase_q  <= 1'b0;
            left_q   <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            lo_q     <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            rv_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            rv_q   <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        if (hit && width_ok) begin
                            tim_q    <= timing;
                            wr_q     <= req_write;
                            split_q  <= split_now;
                            narrow_q <= !req_wide;
                            b8_q     <= bus8;
                            phase_q  <= 1'b0;
                            left_q   <= nbeats;
                            addr_q   <= req_off;
                            wdata_q  <= req_wdata;
                            state_q  <= S_ADDR;
                        end else begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end
                    end
                end
                S_ADDR: begin
                    cnt_q   <= tim_q.a_wait - CNT_W'(1);
                    state_q <= S_AWAIT;
                end
                S_AWAIT, S_DWAIT: begin
                    if (cnt_q == '0) state_q <= S_DATA;
                    else             cnt_q   <= cnt_q - CNT_W'(1);
                end
                S_DATA: begin
                    addr_q <= addr_q + (b8_q ? WIN_BITS'(1) : WIN_BITS'(2));
                    if (split_q) phase_q <= !phase_q;
                    if (!wr_q) begin
                        if (split_q && !phase_q) begin
                            lo_q <= pb_rdata[7:0];
                        end else begin
                            rv_q    <= 1'b1;
                            rdata_q <= split_q  ? {pb_rdata[7:0], lo_q} :
                                       narrow_q ? {8'h00, pb_rdata[7:0]} : pb_rdata;
                        end
                    end
                    if (last_beat) begin
                        cnt_q   <= tim_q.r_wait - CNT_W'(1);
                        done_q  <= 1'b1;
                        state_q <= S_RECOV;
                    end else begin
                        left_q  <= left_q - BEAT_W'(1);
                        cnt_q   <= (wr_q ? tim_q.a_wait : tim_q.d_wait) - CNT_W'(1);
                        state_q <= S_DWAIT;
                    end
                end
                S_RECOV: begin
                    if (cnt_q == '0) state_q <= S_IDLE;
                    else             cnt_q   <= cnt_q - CNT_W'(1);
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != S_IDLE);
        pb_cs_n   = !(state_q inside {S_ADDR, S_AWAIT, S_DATA, S_DWAIT});
        pb_rd_n   = !((state_q == S_DATA) && !wr_q);
        pb_wr_n   = !((state_q == S_DATA) && wr_q);
        pb_addr   = addr_q;
        done      = done_q;
        err       = err_q;
        rsp_valid = rv_q;
        rsp_data  = rdata_q;
        if (split_q)
            pb_wdata = phase_q ? {8'h00, wdata_q[15:8]} : {8'h00, wdata_q[7:0]};
        else if (narrow_q)
            pb_wdata = {8'h00, wdata_q[7:0]};
        else
            pb_wdata = wdata_q;
    end

    // R5: a strobe is always preceded by a cycle with chip-select already low
    a_r5_cs_before_strobe: assert property (@(posedge clk) disable iff (rst)
        (!pb_rd_n || !pb_wr_n) |-> $past(!pb_cs_n))
        else $error("R5 strobe without prior address phase");

    // R6: read strobes never run back to back
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
        !pb_rd_n |=> pb_rd_n)
        else $error("R6 adjacent read strobes");

    // R8: read and write strobes are exclusive
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
        (pb_rd_n || pb_wr_n))
        else $error("R8 both strobes low");

    // R3: an error completion never touched the bus
    a_r3_err_no_bus: assert property (@(posedge clk) disable iff (rst)
        err |-> (pb_cs_n && $past(pb_cs_n) && done))
        else $error("R3 error with bus activity");

    // R11: a good completion follows a strobe directly
    a_r11_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> $past(!pb_rd_n || !pb_wr_n))
        else $error("R11 done not after last strobe");

    // R7: idle is entered only from a cycle with chip-select released
    a_r7_recovery_cs_high: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(pb_cs_n))
        else $error("R7 idle entered with chip-select low");

endmodule

// File: rtl/pbw_seq.sv
module pbw_seq
    import pbw_pkg::*;
#(
    parameter int WIN_BITS = 16,
    parameter int LEN_W    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                boot_narrow_n,
    input  logic                cfg_we,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic                req_valid,
    input  logic [31:0]         req_addr,
    input  logic                req_write,
    input  logic                req_wide,
    input  logic [LEN_W-1:0]    req_len,
    input  logic [15:0]         req_wdata,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic                rsp_valid,
    output logic [15:0]         rsp_data,
    output logic [WIN_BITS-1:0] pb_addr,
    output logic                pb_cs_n,
    output logic                pb_rd_n,
    output logic                pb_wr_n,
    output logic [15:0]         pb_wdata,
    input  logic [15:0]         pb_rdata
);

    win_cfg_t cfg;
    timing_t  timing;
    logic     hit, width_ok, bus8;

    pbw_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .strap_n (boot_narrow_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .cfg     (cfg)
    );

    pbw_decode #(.WIN_BITS(WIN_BITS)) u_dec (
        .cfg      (cfg),
        .req_page (req_addr[31:WIN_BITS]),
        .hit      (hit),
        .width_ok (width_ok),
        .bus8     (bus8),
        .timing   (timing)
    );

    pbw_fsm #(.WIN_BITS(WIN_BITS), .LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wide  (req_wide),
        .req_len   (req_len),
        .req_off   (req_addr[WIN_BITS-1:0]),
        .req_wdata (req_wdata),
        .hit       (hit),
        .width_ok  (width_ok),
        .bus8      (bus8),
        .timing    (timing),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .pb_addr   (pb_addr),
        .pb_cs_n   (pb_cs_n),
        .pb_rd_n   (pb_rd_n),
        .pb_wr_n   (pb_wr_n),
        .pb_wdata  (pb_wdata),
        .pb_rdata  (pb_rdata)
    );

    assign cfg_rdata = cfg;

endmodule

// File: tb/tb_pbw_seq.sv
module tb_pbw_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_narrow_n = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [3:0]  req_len = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, err, rsp_valid;
    logic [15:0] rsp_data, pb_addr, pb_wdata, pb_rdata;
    logic        pb_cs_n, pb_rd_n, pb_wr_n;

    always #4 clk = ~clk;

    pbw_seq #(.WIN_BITS(16), .LEN_W(4)) dut (.*);

    function automatic logic [15:0] rdfn(input logic [15:0] a);
        return 16'(a * 16'd37 + 16'd5);
    endfunction
    assign pb_rdata = rdfn(pb_addr);

    int checks = 0;
    int failures = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;
    logic [31:0] shadow;

    typedef struct {
        bit cs_n, rd_n, wr_n, busy, done, err, rv;
        logic [15:0] addr, wdata, rdata;
        string tag;
    } exp_t;
    exp_t q[$];

    function automatic int ad_tab(input logic [2:0] c);
        case (c) 3'd0: return 4; 3'd1: return 8; 3'd2: return 12; 3'd3: return 16; default: return 20; endcase
    endfunction
    function automatic int dd_tab(input logic [2:0] c, input logic [2:0] a);
        case (c) 3'd0, 3'd1: return ad_tab(a); 3'd2: return 4; 3'd3: return 8;
                 3'd4: return 12; 3'd5: return 16; default: return 20; endcase
    endfunction
    function automatic int rec_tab(input logic [2:0] c);
        case (c) 3'd0: return 1; 3'd1: return 4; 3'd2: return 8; 3'd3: return 12;
                 3'd4: return 16; default: return 20; endcase
    endfunction
    function automatic logic [31:0] mkcfg(input logic [31:0] base, input int dd, input int rec,
                                          input int ad, input int w);
        return base | 32'(dd << 9) | 32'(rec << 6) | 32'(ad << 2) | 32'(w);
    endfunction
    function automatic exp_t mk(input bit cs, input bit rd, input bit wr, input bit b, input string t);
        exp_t e;
        e.cs_n = cs; e.rd_n = rd; e.wr_n = wr; e.busy = b;
        e.done = 0; e.err = 0; e.rv = 0; e.addr = '0; e.wdata = '0; e.rdata = '0; e.tag = t;
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, expv);
        end
    endtask

    // per-cycle comparison against the behavioural model
    always @(negedge clk) begin
        if (mon_en) begin
            exp_t e;
            bit bad;
            if (q.size() > 0) e = q.pop_front();
            else e = mk(1, 1, 1, 0, "R7");
            bad = (pb_cs_n !== e.cs_n) || (pb_rd_n !== e.rd_n) || (pb_wr_n !== e.wr_n) ||
                  (busy !== e.busy) || (done !== e.done) || (err !== e.err) || (rsp_valid !== e.rv);
            if (!e.rd_n || !e.wr_n) bad = bad || (pb_addr !== e.addr);
            if (!e.wr_n) bad = bad || (pb_wdata !== e.wdata);
            if (e.rv) bad = bad || (rsp_data !== e.rdata);
            checks++;
            if (bad) begin
                failures++;
                $display("FAIL %s got cs=%b rd=%b wr=%b busy=%b done=%b err=%b rv=%b addr=%h wd=%h rsp=%h exp cs=%b rd=%b wr=%b busy=%b done=%b err=%b rv=%b addr=%h wd=%h rsp=%h",
                         e.tag, pb_cs_n, pb_rd_n, pb_wr_n, busy, done, err, rsp_valid, pb_addr, pb_wdata, rsp_data,
                         e.cs_n, e.rd_n, e.wr_n, e.busy, e.done, e.err, e.rv, e.addr, e.wdata, e.rdata);
            end
        end
    end

    task automatic do_reset(input bit strap);
        mon_en = 1'b0;
        q.delete();
        rst = 1'b1;
        boot_narrow_n = strap;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        shadow = strap ? 32'h3DD : 32'h3DC;
    endtask

    task automatic cfg_wr(input logic [31:0] v);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); #2;
        cfg_we = 1'b0;
        shadow = v & 32'hFFFF_FFDF;
    endtask

    task automatic access(input logic [31:0] addr, input bit wr, input bit wide,
                          input int len, input logic [15:0] wd);
        int a, d, r, items, nb, step, gap;
        bit b8, split, pend;
        logic [15:0] off, baddr, pdata;
        logic [7:0] lo;
        string gt;
        exp_t e;
        @(posedge clk); #2;
        while (q.size() != 0) begin @(posedge clk); #2; end
        a = ad_tab(shadow[4:2]);
        d = dd_tab(shadow[11:9], shadow[4:2]);
        r = rec_tab(shadow[8:6]);
        b8 = (shadow[1:0] == 2'b00);
        q.push_back(mk(1, 1, 1, 0, "R7"));
        if (addr[31:16] != shadow[31:16] || shadow[1]) begin
            e = mk(1, 1, 1, 0, (addr[31:16] != shadow[31:16]) ? "R3" : "R4");
            e.done = 1; e.err = 1;
            q.push_back(e);
        end else begin
            split = b8 && wide;
            items = wr ? 1 : len + 1;
            nb = split ? 2 * items : items;
            step = b8 ? 1 : 2;
            off = addr[15:0];
            pend = 0; pdata = '0; lo = '0;
            q.push_back(mk(0, 1, 1, 1, "R5"));
            for (int b = 0; b < nb; b++) begin
                gap = (b == 0 || wr) ? a : d;
                gt = (b == 0) ? "R5" : (wr ? "R8" : "R6");
                for (int g = 0; g < gap; g++) begin
                    e = mk(0, 1, 1, 1, gt);
                    if (pend) begin e.rv = 1; e.rdata = pdata; e.tag = "R11"; pend = 0; end
                    q.push_back(e);
                end
                baddr = 16'(off + 16'(b * step));
                e = mk(0, wr, !wr, 1, split ? "R9" : "R10");
                e.addr = baddr;
                if (split) e.wdata = (b % 2 == 1) ? {8'h00, wd[15:8]} : {8'h00, wd[7:0]};
                else if (wide) e.wdata = wd;
                else e.wdata = {8'h00, wd[7:0]};
                q.push_back(e);
                if (!wr) begin
                    if (split && (b % 2 == 0)) lo = rdfn(baddr) & 16'hFF;
                    else begin
                        pend = 1;
                        if (split) pdata = {rdfn(baddr)[7:0], lo};
                        else if (wide) pdata = rdfn(baddr);
                        else pdata = {8'h00, rdfn(baddr)[7:0]};
                    end
                end
            end
            for (int k = 0; k < r; k++) begin
                e = mk(1, 1, 1, 1, "R7");
                if (k == 0) begin
                    e.done = 1; e.tag = "R11";
                    if (pend) begin e.rv = 1; e.rdata = pdata; pend = 0; end
                end
                q.push_back(e);
            end
        end
        req_valid = 1'b1; req_addr = addr; req_write = wr; req_wide = wide;
        req_len = 4'(len); req_wdata = wd;
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        @(posedge clk); #2;
        while (q.size() != 0) begin @(posedge clk); #2; end
        repeat (2) @(posedge clk);
        #2;
    endtask

    localparam logic [31:0] BASE = 32'hABCD_0000;

    initial begin
        // R1: reset value with strap asserted and released
        do_reset(1'b0);
        check(cfg_rdata == 32'h3DC, "R1 reset word strap low", cfg_rdata, 32'h3DC);
        do_reset(1'b1);
        check(cfg_rdata == 32'h3DD, "R1 reset word strap high", cfg_rdata, 32'h3DD);
        check(busy == 1'b0 && pb_cs_n == 1'b1, "R1 idle after reset", {30'd0, busy, pb_cs_n}, 32'd1);
        mon_en = 1'b1;

        // R2: bit 5 never stored
        cfg_wr(32'hFFFF_FFFF);
        check(cfg_rdata == 32'hFFFF_FFDF, "R2 reserved bit", cfg_rdata, 32'hFFFF_FFDF);
        cfg_wr(mkcfg(BASE, 3, 2, 1, 1));
        check(cfg_rdata == mkcfg(BASE, 3, 2, 1, 1), "R2 field readback", cfg_rdata, mkcfg(BASE, 3, 2, 1, 1));

        // R5 and R6 fallback: every address-to-data code, burst of two
        for (int c = 0; c < 8; c++) begin
            cfg_wr(mkcfg(BASE, c % 2, 0, c, 1));
            access(BASE + 32'h100, 0, 1, 1, 16'h0);
        end
        // R6: explicit data-to-data codes
        for (int c = 2; c < 8; c++) begin
            cfg_wr(mkcfg(BASE, c, 0, 0, 1));
            access(BASE + 32'h180, 0, 1, 2, 16'h0);
        end
        // R7: recovery codes
        for (int c = 0; c < 8; c++) begin
            cfg_wr(mkcfg(BASE, 2, c, 0, 1));
            access(BASE + 32'h40, 0, 1, 0, 16'h0);
        end
        // R8, R10: 16-bit writes, wide and narrow
        cfg_wr(mkcfg(BASE, 2, 1, 1, 1));
        access(BASE + 32'h200, 1, 1, 5, 16'hBEEF);
        access(BASE + 32'h210, 1, 0, 0, 16'hA55A);
        // R10: narrow read burst on 16-bit bus
        access(BASE + 32'h220, 0, 0, 2, 16'h0);
        // R9, R8: 8-bit bus splits
        cfg_wr(mkcfg(BASE, 3, 1, 0, 0));
        access(BASE + 32'h300, 1, 1, 0, 16'h1234);
        access(BASE + 32'h401, 0, 1, 1, 16'h0);
        access(BASE + 32'h500, 0, 0, 2, 16'h0);
        // R3: miss
        access(32'hABCE_0010, 0, 1, 0, 16'h0);
        access(32'h0000_0010, 1, 1, 0, 16'h7777);
        // R4: reserved widths
        cfg_wr(mkcfg(BASE, 2, 0, 0, 2));
        access(BASE + 32'h10, 0, 1, 0, 16'h0);
        cfg_wr(mkcfg(BASE, 2, 0, 0, 3));
        access(BASE + 32'h10, 1, 1, 0, 16'h1111);
        // R12: setup write while an access runs
        cfg_wr(mkcfg(BASE, 7, 7, 7, 1));
        access(BASE + 32'h600, 0, 1, 3, 16'h0);
        cfg_wr(mkcfg(BASE, 2, 0, 0, 1));
        access(BASE + 32'h700, 0, 1, 1, 16'h0);
        drain();
        check(cfg_rdata == mkcfg(BASE, 2, 0, 0, 1), "R12 setup kept", cfg_rdata, mkcfg(BASE, 2, 0, 0, 1));

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R7 got=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule